// File: doc/BRIEF.md
# Forward 4x4 Integer Transform

This block turns a 4x4 tile of signed 16-bit residual samples into sixteen signed 16-bit transform coefficients. It uses a separable butterfly transform with fixed integer multipliers. The first pass runs along each input row, scales the sums and differences by eight, and is applied as each row arrives. Its results are written into a transpose buffer. When all four rows are held, the second pass runs down the columns and streams the coefficients out, one row of four per beat.

Input rows are offered with a valid/ready pair, and each beat carries eight sample lanes. In the default 4-wide mode only lanes 0..3 take part. In wide mode the eight lanes form two adjacent 4x4 tiles, and the block emits eight output beats: four for the left tile, then four for the right tile. The mode is captured on the first row beat of each tile. While the buffer holds a finished tile, input is refused until the last coefficient row has been taken.

Top module: `fdct_fwd4x4`

## Requirements
- R1: First pass, per row x0..x3 (lane j in in_row_i bits [16j+15:16j]): a=(x0+x3)*8, b=(x1+x2)*8, c=(x1-x2)*8, d=(x0-x3)*8; t0=a+b, t2=a-b.
- R2: First pass odd terms, computed at 32 bits and saturated to 16 bits: t1=(c*2217+d*5352+14500)>>>12 and t3=(d*2217-c*5352+7500)>>>12.
- R3: Second pass, per column u0..u3 (top to bottom): a=u0+u3, b=u1+u2, with no scaling. Y0=(a+b+7)>>>4 and Y2=(a-b+7)>>>4, both in 16 bits.
- R4: Second pass Y1 = sat16((c*2217+d*5352+12000)>>>16) + 1 when d=u0-u3 is nonzero, and + 0 when d is zero, with c=u1-u2.
- R5: Second pass Y3 = sat16((d*2217-c*5352+51000)>>>16).
- R6: Output beat m carries coefficient row Y_m, with column k in out_row_o bits [16k+15:16k]. Input row beats arrive top row first.
- R7: wide_i is sampled only on the first row beat of a tile. When it is 1, lanes 4..7 form a second tile and eight beats come out, left tile first. When it is 0, lanes 4..7 have no effect and four beats come out.
- R8: in_ready_o and out_valid_o are never high together. After the fourth accepted row, input is refused, and in_valid_i has no effect until the final output beat is accepted. After that beat, in_ready_o returns the next cycle.
- R9: While out_valid_o is high and out_ready_i is low, out_row_o and out_valid_o hold.
- R10: During reset, in_ready_o is 1 and out_valid_o is 0.
- R11: The sums, differences and the first-pass scaling are 16-bit two's complement and wrap on overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wide_i | input | 1 | 1 selects the two-tile 8x4 mode (sampled on the first row) |
| in_valid_i | input | 1 | Input row valid |
| in_ready_o | output | 1 | Block can accept a row |
| in_row_i | input | 128 | Eight signed 16-bit samples, lane 0 in the LSBs |
| out_valid_o | output | 1 | Coefficient row valid |
| out_ready_i | input | 1 | Sink accepts the coefficient row |
| out_row_o | output | 64 | Four signed 16-bit coefficients, column 0 in the LSBs |

## Verification
Two events can meet in one cycle: the sink taking the final coefficient row while the source is already presenting the next tile's first row, and the sink stalling while a new row is offered. The bench holds out_ready_i low with in_valid_i high and junk data for several cycles. It then checks that the block refuses the junk, that the output stays fixed, and that the next tile's coefficients are exact. It also keeps a row pending across the final drain beat, to confirm the row is accepted only after in_ready_o rises.

// File: rtl/fdct_pkg.sv
package fdct_pkg;
  localparam int unsigned SAMPLE_W = 16;
  localparam int unsigned ACC_W    = 32;
  localparam int unsigned N        = 4;
  localparam int unsigned HALVES   = 2;

  localparam int K_COS  = 2217;
  localparam int K_SIN  = 5352;
  localparam int SCALE_SH = 3;
  localparam int P1_SH  = 12;
  localparam int P1_RND1 = 14500;
  localparam int P1_RND3 = 7500;
  localparam int P2_EVEN_SH  = 4;
  localparam int P2_EVEN_RND = 7;
  localparam int P2_SH  = 16;
  localparam int P2_RND1 = 12000;
  localparam int P2_RND3 = 51000;

  typedef logic signed [SAMPLE_W-1:0] coef_t;
  typedef logic signed [ACC_W-1:0]    acc_t;
  typedef coef_t [N-1:0]              quad_t;
  typedef coef_t [N*HALVES-1:0]       wrow_t;

  typedef enum logic {ST_FILL, ST_DRAIN} st_e;

  localparam acc_t SAT_MAX = acc_t'((2 ** (SAMPLE_W - 1)) - 1);
  localparam acc_t SAT_MIN = -SAT_MAX - acc_t'(1);

  function automatic coef_t sat_coef(input acc_t v);
    if (v > SAT_MAX)      return coef_t'(SAT_MAX);
    else if (v < SAT_MIN) return coef_t'(SAT_MIN);
    else                  return coef_t'(v);
  endfunction
endpackage

// File: rtl/fdct_row_pass.sv
module fdct_row_pass
  import fdct_pkg::*;
(
  input  quad_t x_i,
  output quad_t y_o
);
  coef_t x0, x1, x2, x3;
  coef_t s03, s12, d12, d03;
  coef_t a1, b1, c1, d1;
  acc_t  cw, dw, odd1, odd3;

  always_comb begin
    x0 = x_i[0];
    x1 = x_i[1];
    x2 = x_i[2];
    x3 = x_i[3];
    s03 = x0 + x3;
    s12 = x1 + x2;
    d12 = x1 - x2;
    d03 = x0 - x3;
    // scale by 8 in 16 bits, wraps
    a1 = s03 <<< SCALE_SH;
    b1 = s12 <<< SCALE_SH;
    c1 = d12 <<< SCALE_SH;
    d1 = d03 <<< SCALE_SH;
    cw = c1;
    dw = d1;
    odd1 = cw * acc_t'(K_COS) + dw * acc_t'(K_SIN) + acc_t'(P1_RND1);
    odd3 = dw * acc_t'(K_COS) - cw * acc_t'(K_SIN) + acc_t'(P1_RND3);
    y_o[0] = a1 + b1;
    y_o[2] = a1 - b1;
    y_o[1] = sat_coef(odd1 >>> P1_SH);
    y_o[3] = sat_coef(odd3 >>> P1_SH);
  end
endmodule

// File: rtl/fdct_col_pass.sv
module fdct_col_pass
  import fdct_pkg::*;
(
  input  quad_t x_i,
  output quad_t y_o
);
  coef_t u0, u1, u2, u3;
  coef_t a1, b1, c1, d1;
  coef_t ev0, ev2;
  acc_t  cw, dw, odd1, odd3;

  always_comb begin
    u0 = x_i[0];
    u1 = x_i[1];
    u2 = x_i[2];
    u3 = x_i[3];
    a1 = u0 + u3;
    b1 = u1 + u2;
    c1 = u1 - u2;
    d1 = u0 - u3;
    ev0 = a1 + b1 + coef_t'(P2_EVEN_RND);
    ev2 = a1 - b1 + coef_t'(P2_EVEN_RND);
    cw = c1;
    dw = d1;
    odd1 = cw * acc_t'(K_COS) + dw * acc_t'(K_SIN) + acc_t'(P2_RND1);
    odd3 = dw * acc_t'(K_COS) - cw * acc_t'(K_SIN) + acc_t'(P2_RND3);
    y_o[0] = ev0 >>> P2_EVEN_SH;
    y_o[2] = ev2 >>> P2_EVEN_SH;
    // bump when the outer difference is nonzero
    y_o[1] = sat_coef(odd1 >>> P2_SH) + coef_t'(d1 != '0);
    y_o[3] = sat_coef(odd3 >>> P2_SH);
  end
endmodule

// File: rtl/fdct_tbuf.sv
module fdct_tbuf
  import fdct_pkg::*;
#(
  parameter int unsigned DEPTH = N,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  wrow_t             wdata_i,
  output wrow_t [DEPTH-1:0] rows_o
);
  wrow_t [DEPTH-1:0] mem_q;

  for (genvar r = 0; r < DEPTH; r++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             mem_q[r] <= '0;
      else if (we_i && waddr_i == AW'(r))      mem_q[r] <= wdata_i;
    end
  end

  assign rows_o = mem_q;
endmodule

// File: rtl/fdct_fwd4x4.sv
module fdct_fwd4x4
  import fdct_pkg::*;
#(
  localparam int unsigned ROW_W  = N * HALVES * SAMPLE_W,
  localparam int unsigned OUT_W  = N * SAMPLE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wide_i,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [ROW_W-1:0] in_row_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [OUT_W-1:0] out_row_o
);
  localparam int unsigned CNT_W = $clog2(N);
  localparam int unsigned DRN_W = $clog2(N * HALVES);
  localparam int unsigned HS_W  = DRN_W - CNT_W;

  st_e              st_q;
  logic [CNT_W-1:0] fill_q;
  logic [DRN_W-1:0] drn_q;
  logic             wide_q;
  logic [DRN_W-1:0] last_idx;
  logic [HS_W-1:0]  half_sel;
  logic [CNT_W-1:0] coef_sel;
  logic             wr_en;

  wrow_t            in_w;
  wrow_t            p1;
  wrow_t [N-1:0]    rows;
  quad_t            out_w;

  assign in_w = in_row_i;

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    quad_t rx, ry;
    assign rx = in_w[h*N +: N];
    fdct_row_pass u_rp (.x_i(rx), .y_o(ry));
    assign p1[h*N +: N] = ry;
  end

  assign wr_en = in_valid_i && in_ready_o;

  fdct_tbuf #(.DEPTH(N)) u_tbuf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_en),
    .waddr_i(fill_q),
    .wdata_i(p1),
    .rows_o (rows)
  );

  assign half_sel = drn_q[DRN_W-1:CNT_W];
  assign coef_sel = drn_q[CNT_W-1:0];

  for (genvar k = 0; k < N; k++) begin : g_col
    quad_t col_in, col_out;
    always_comb begin
      for (int r = 0; r < N; r++) col_in[r] = rows[r][int'(half_sel) * N + k];
    end
    fdct_col_pass u_cp (.x_i(col_in), .y_o(col_out));
    assign out_w[k] = col_out[coef_sel];
  end

  assign last_idx = wide_q ? DRN_W'(N * HALVES - 1) : DRN_W'(N - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_FILL;
      fill_q <= '0;
      drn_q  <= '0;
      wide_q <= 1'b0;
    end else begin
      case (st_q)
        ST_FILL: if (in_valid_i) begin
          if (fill_q == '0) wide_q <= wide_i;
          if (fill_q == CNT_W'(N - 1)) begin
            fill_q <= '0;
            drn_q  <= '0;
            st_q   <= ST_DRAIN;
          end else begin
            fill_q <= fill_q + CNT_W'(1);
          end
        end
        ST_DRAIN: if (out_ready_i) begin
          if (drn_q == last_idx) begin
            drn_q <= '0;
            st_q  <= ST_FILL;
          end else begin
            drn_q <= drn_q + DRN_W'(1);
          end
        end
        default: st_q <= ST_FILL;
      endcase
    end
  end

  assign in_ready_o  = (st_q == ST_FILL);
  assign out_valid_o = (st_q == ST_DRAIN);
  assign out_row_o   = out_w;
endmodule

// File: rtl/fdct_fwd4x4_chk.sv
module fdct_fwd4x4_chk
  import fdct_pkg::*;
(
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  wide_i,
  input logic                  in_valid_i,
  input logic                  in_ready_o,
  input logic                  out_valid_o,
  input logic                  out_ready_i,
  input logic [N*SAMPLE_W-1:0] out_row_o
);
  localparam int unsigned CW = $clog2(N);
  localparam int unsigned OW = $clog2(N * HALVES);

  logic [CW-1:0] acc_cnt;
  logic [OW-1:0] out_cnt;
  logic          wide_seen;
  logic [OW-1:0] out_last;

  assign out_last = wide_seen ? OW'(N * HALVES - 1) : OW'(N - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_cnt   <= '0;
      out_cnt   <= '0;
      wide_seen <= 1'b0;
    end else begin
      if (in_valid_i && in_ready_o) begin
        acc_cnt <= acc_cnt + CW'(1);
        if (acc_cnt == '0) wide_seen <= wide_i;
      end
      if (out_valid_o && out_ready_i)
        out_cnt <= (out_cnt == out_last) ? '0 : out_cnt + OW'(1);
    end
  end

  p_one_side_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o != out_valid_o);

  p_full_stalls_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && acc_cnt == CW'(N - 1)) |=> (out_valid_o && !in_ready_o));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_row_o)));

  p_last_beat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && out_cnt == out_last) |=> in_ready_o);

  p_mid_beat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && out_cnt != out_last) |=> out_valid_o);
endmodule

bind fdct_fwd4x4 fdct_fwd4x4_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wide_i     (wide_i),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i),
  .out_row_o  (out_row_o)
);

// File: tb/test_fdct_fwd4x4.sv
module test_fdct_fwd4x4;
  localparam int CLK_P = 10;

  typedef int blk_t [4][8];
  typedef int res_t [2][4][4];

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         wide_i = 1'b0;
  logic         in_valid_i = 1'b0;
  logic         in_ready_o;
  logic [127:0] in_row_i = '0;
  logic         out_valid_o;
  logic         out_ready_i = 1'b0;
  logic [63:0]  out_row_o;

  int n_tests = 0;
  int n_fail  = 0;
  int seed    = 32'h1234_5678;
  bit done    = 1'b0;

  always #(CLK_P / 2) clk_i = ~clk_i;

  fdct_fwd4x4 i_fdct_fwd4x4 (
    .clk_i(clk_i), .rst_ni(rst_ni), .wide_i(wide_i),
    .in_valid_i(in_valid_i), .in_ready_o(in_ready_o), .in_row_i(in_row_i),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_row_o(out_row_o)
  );

  function automatic int w16(input int v);
    return int'(shortint'(v));
  endfunction

  function automatic int sat16(input int v);
    return (v > 32767) ? 32767 : ((v < -32768) ? -32768 : v);
  endfunction

  function automatic void model(input blk_t x, output res_t y);
    int t [4][8];
    for (int r = 0; r < 4; r++) begin
      for (int h = 0; h < 2; h++) begin
        int a, b, c, e;
        a = w16(w16(x[r][4*h] + x[r][4*h+3]) * 8);
        b = w16(w16(x[r][4*h+1] + x[r][4*h+2]) * 8);
        c = w16(w16(x[r][4*h+1] - x[r][4*h+2]) * 8);
        e = w16(w16(x[r][4*h] - x[r][4*h+3]) * 8);
        t[r][4*h]   = w16(a + b);
        t[r][4*h+2] = w16(a - b);
        t[r][4*h+1] = sat16((c * 2217 + e * 5352 + 14500) >>> 12);
        t[r][4*h+3] = sat16((e * 2217 - c * 5352 + 7500) >>> 12);
      end
    end
    for (int h = 0; h < 2; h++) begin
      for (int k = 0; k < 4; k++) begin
        int a, b, c, e, col;
        col = 4 * h + k;
        a = w16(t[0][col] + t[3][col]);
        b = w16(t[1][col] + t[2][col]);
        c = w16(t[1][col] - t[2][col]);
        e = w16(t[0][col] - t[3][col]);
        y[h][0][k] = w16(a + b + 7) >>> 4;
        y[h][2][k] = w16(a - b + 7) >>> 4;
        y[h][1][k] = w16(sat16((c * 2217 + e * 5352 + 12000) >>> 16) + ((e != 0) ? 1 : 0));
        y[h][3][k] = sat16((e * 2217 - c * 5352 + 51000) >>> 16);
      end
    end
  endfunction

  function automatic logic [127:0] pack_in(input blk_t x, input int r);
    logic [127:0] v;
    for (int j = 0; j < 8; j++) v[16*j +: 16] = 16'(x[r][j]);
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic push_row(input logic [127:0] r);
    in_row_i   = r;
    in_valid_i = 1'b1;
    while (!in_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    in_valid_i = 1'b0;
  endtask

  task automatic pop_row(output logic [63:0] r);
    out_ready_i = 1'b1;
    while (!out_valid_o) @(negedge clk_i);
    r = out_row_o;
    @(negedge clk_i);
    out_ready_i = 1'b0;
  endtask

  task automatic rand_blk(output blk_t x, input int span);
    for (int r = 0; r < 4; r++) begin
      for (int j = 0; j < 8; j++) begin
        seed = seed * 1103515245 + 12345;
        x[r][j] = ((seed >>> 8) % span);
      end
    end
  endtask

  // feeds one tile, optionally stalls the sink, checks every coefficient row
  task automatic run_block(input blk_t x, input bit wide, input string req, input int stall);
    res_t y;
    logic [63:0] act, exp, held;
    int beats;
    model(x, y);
    beats = wide ? 8 : 4;
    wide_i = wide;
    for (int r = 0; r < 4; r++) begin
      push_row(pack_in(x, r));
      wide_i = !wide;  // later beats must not change the mode (R7)
    end
    if (stall > 0) begin
      in_valid_i = 1'b1;
      in_row_i   = {8{16'h5a5a}};
      held = out_row_o;
      chk(out_valid_o && !in_ready_o, "R8", "full buffer refuses input",
          {62'd0, out_valid_o, in_ready_o}, 64'd2);
      for (int s = 0; s < stall; s++) begin
        @(negedge clk_i);
        chk(out_valid_o && out_row_o == held, "R9", "row held under stall", out_row_o, held);
      end
      in_valid_i = 1'b0;
    end
    for (int m = 0; m < beats; m++) begin
      pop_row(act);
      for (int k = 0; k < 4; k++) exp[16*k +: 16] = 16'(y[m / 4][m % 4][k]);
      chk(act == exp, req, $sformatf("beat %0d", m), act, exp);
    end
    chk(in_ready_o && !out_valid_o, "R8", "ready after last beat",
        {62'd0, out_valid_o, in_ready_o}, 64'd1);
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    chk(in_ready_o && !out_valid_o, "R10", "reset state",
        {62'd0, out_valid_o, in_ready_o}, 64'd1);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic t_ramp();
    blk_t x;
    for (int r = 0; r < 4; r++)
      for (int j = 0; j < 8; j++) x[r][j] = (r * 4 + j) * 3 - 20;
    run_block(x, 1'b0, "R1 R2 R3 R4 R5 R6 ramp", 0);
  endtask

  task automatic t_flat();
    blk_t x;
    for (int r = 0; r < 4; r++)
      for (int j = 0; j < 8; j++) x[r][j] = 5;
    run_block(x, 1'b0, "R4 zero outer difference", 0);
  endtask

  task automatic t_random();
    blk_t x;
    for (int i = 0; i < 6; i++) begin
      rand_blk(x, (i < 3) ? 256 : 2048);
      run_block(x, 1'b0, "R1 R2 R3 R5 random, R7 upper lanes ignored", 0);
    end
  endtask

  task automatic t_extreme();
    blk_t x;
    for (int r = 0; r < 4; r++) begin
      x[r][0] = (r < 2) ? 4000 : 20000;
      x[r][1] = 4000 - r * 1000;
      x[r][2] = -r * 900;
      x[r][3] = (r < 2) ? 0 : 20000;
      for (int j = 4; j < 8; j++) x[r][j] = -32768 + r * 77 + j;
    end
    run_block(x, 1'b1, "R2 saturate, R11 wrap", 0);
  endtask

  task automatic t_wide();
    blk_t x;
    rand_blk(x, 1024);
    run_block(x, 1'b1, "R7 wide left then right", 0);
    rand_blk(x, 512);
    run_block(x, 1'b0, "R7 narrow after wide", 0);
  endtask

  task automatic t_backpressure();
    blk_t x;
    rand_blk(x, 600);
    run_block(x, 1'b1, "R8 R9 stalled sink", 5);
    rand_blk(x, 300);
    run_block(x, 1'b0, "R8 junk not absorbed", 3);
  endtask

  task automatic t_overlap();
    blk_t x, z;
    res_t y;
    logic [63:0] act, exp;
    rand_blk(x, 400);
    rand_blk(z, 400);
    model(z, y);
    wide_i = 1'b0;
    for (int r = 0; r < 4; r++) push_row(pack_in(x, r));
    // pending next-tile row while draining
    in_row_i = pack_in(z, 0);
    in_valid_i = 1'b1;
    for (int m = 0; m < 4; m++) pop_row(act);
    chk(in_ready_o, "R8", "pending row accepted after drain", {63'd0, in_ready_o}, 64'd1);
    @(negedge clk_i);
    in_valid_i = 1'b0;
    for (int r = 1; r < 4; r++) push_row(pack_in(z, r));
    for (int m = 0; m < 4; m++) begin
      pop_row(act);
      for (int k = 0; k < 4; k++) exp[16*k +: 16] = 16'(y[0][m][k]);
      chk(act == exp, "R8 R6 overlap tile", $sformatf("beat %0d", m), act, exp);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_ramp();
    t_flat();
    t_random();
    t_extreme();
    t_wide();
    t_backpressure();
    t_overlap();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule